// File: doc/BRIEF.md
# Relocating Memory Bus Request Encoder

This block sits on the processor side of a memory bus and drives its control cables. When it is told to load a new address, it adds a relocation value to the block part of a relative address. It then packs the result into a 32-bit bus control word. The low offset bits and the low block bits travel single-rail. The high block bits, the address least significant bit and the fast-memory select each travel as dual-rail pairs, with one "one" line and one "zero" line per pair. One high block bit also has an extra single-rail copy.

The block also drives the request strobes: read, write, cycle request and write restart. The cycle request is gated by read or write intent. The block watches the address-acknowledge and read-restart lines coming back from memory, and turns each leading edge into a one-cycle pulse. While a read is active, returned data words are ORed into a memory buffer register. Every output is registered, and the reset is synchronous and active high.

Top module: `mbus_req_enc`

## Requirements
- R1: After reset, `bus_ctl`, `ack_pulse`, `rdrs_pulse` and `mbuf` are all zero.
- R2: On a cycle with `addr_load` high, the relocated block is `rel_addr[17:10] + reloc`, taken modulo 256. The packed fields appear in `bus_ctl` after that clock edge.
- R3: `bus_ctl[13:4]` carries `rel_addr[9:0]`, and `bus_ctl[17:14]` carries relocated block bits 3..0.
- R4: Each relocated block bit k, for k from 4 to 7, drives a dual-rail pair. The "one" line is at `bus_ctl[18+2*(k-4)]` and the "zero" line is at `bus_ctl[19+2*(k-4)]`, and exactly one of the two is high. `bus_ctl[0]` is a single-rail copy that is high when block bit 4 is 1.
- R5: `rel_addr[0]` drives the pair at `bus_ctl[26]` (one) and `bus_ctl[27]` (zero).
- R6: `fast_sel` drives the pair at `bus_ctl[1]` (one) and `bus_ctl[2]` (zero). `bus_ctl[3]` is always zero.
- R7: Each load replaces every address and select field completely, so no bit from an earlier request remains. Between loads, bits 27..0 hold their value.
- R8: One clock after they are sampled, `bus_ctl[29]` follows `rd_req` and `bus_ctl[30]` follows `wr_req`. `bus_ctl[28]` (cycle request) equals `cyc_req & (rd_req | wr_req)`, so it is re-evaluated whenever the read or write flag changes.
- R9: A one-cycle `wr_rs_send` raises `bus_ctl[31]` for exactly one cycle, and the line then clears by itself. `bus_ctl[31]` is never high on two cycles in a row.
- R10: When `ack_in` or `rdrs_in` is first sampled high, the matching pulse output is high for the cycle after that edge. An input that stays high produces no further pulse.
- R11: On each edge where `bus_ctl[29]` is high, `mbuf` takes `mbuf | rdata`. When the read strobe is low, `rdata` is ignored. A load clears `mbuf`, and the load takes priority over the OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rel_addr | input | 18 | Relative address: bits 17..10 are the block, bits 9..0 the offset |
| reloc | input | 8 | Relocation value added to the block |
| addr_load | input | 1 | Load a new address and select; clears the memory buffer |
| fast_sel | input | 1 | Fast-memory select |
| cyc_req | input | 1 | Cycle request pending |
| rd_req | input | 1 | Read wanted |
| wr_req | input | 1 | Write wanted |
| wr_rs_send | input | 1 | Send a write restart |
| ack_in | input | 1 | Address-acknowledge line from memory |
| rdrs_in | input | 1 | Read-restart line from memory |
| rdata | input | DATA_W | Data cables from memory |
| bus_ctl | output | 32 | Packed bus control word |
| ack_pulse | output | 1 | One-cycle pulse on an acknowledge leading edge |
| rdrs_pulse | output | 1 | One-cycle pulse on a read-restart leading edge |
| mbuf | output | DATA_W | Memory buffer of accumulated read data |

## Verification
The hardest situation to reach from the ports is stale dual-rail state. A load must clear a pair's "one" line when the new value drops that bit, while a neighbouring field keeps an equal value. The stimulus reaches this by sweeping every block value against several relocation values, including ones that wrap around modulo 256, so that every rail flips in both directions between consecutive loads. The read-data OR is driven with overlapping bit patterns, so that an overwrite can be told apart from an accumulate.

// File: rtl/mbus_req_pkg.sv
package mbus_req_pkg;
  localparam int CTL_W    = 32;
  localparam int ADDR_W   = 18;
  localparam int OFS_W    = 10;
  localparam int BLK_W    = ADDR_W - OFS_W;
  localparam int BLK_LO_W = 4;
  localparam int BLK_HI_W = BLK_W - BLK_LO_W;
  // bit positions on the control word
  localparam int B_HI_SINGLE = 0;
  localparam int B_SEL_ONE   = 1;
  localparam int B_SEL_ZERO  = 2;
  localparam int B_OFS_LSB   = 4;
  localparam int B_BLK_LSB   = B_OFS_LSB + OFS_W;
  localparam int B_PAIR_LSB  = B_BLK_LSB + BLK_LO_W;
  localparam int B_LSB_ONE   = B_PAIR_LSB + 2 * BLK_HI_W;
  localparam int B_LSB_ZERO  = B_LSB_ONE + 1;
  localparam int B_CYC       = 28;
  localparam int B_RD        = 29;
  localparam int B_WR        = 30;
  localparam int B_WRS       = 31;
  localparam int EDGE_N      = 2;
endpackage

// File: rtl/mbus_addr_packer.sv
module mbus_addr_packer
  import mbus_req_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] rel_addr,
  input  logic [BLK_W-1:0]  reloc,
  input  logic              fast_sel,
  output logic [CTL_W-1:0]  fields
);
  logic [BLK_W-1:0] blk;
  logic [CTL_W-1:0] packed_w;

  assign blk = rel_addr[ADDR_W-1:OFS_W] + reloc;

  always_comb begin
    packed_w = '0;
    packed_w[B_SEL_ONE]  = fast_sel;
    packed_w[B_SEL_ZERO] = ~fast_sel;
    packed_w[B_OFS_LSB +: OFS_W]   = rel_addr[OFS_W-1:0];
    packed_w[B_BLK_LSB +: BLK_LO_W] = blk[BLK_LO_W-1:0];
    packed_w[B_HI_SINGLE] = blk[BLK_LO_W];
    packed_w[B_LSB_ONE]  = rel_addr[0];
    packed_w[B_LSB_ZERO] = ~rel_addr[0];
    for (int k = 0; k < BLK_HI_W; k++) begin
      packed_w[B_PAIR_LSB + 2*k]     = blk[BLK_LO_W + k];
      packed_w[B_PAIR_LSB + 2*k + 1] = ~blk[BLK_LO_W + k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       fields <= '0;
    else if (load) fields <= packed_w;
  end
endmodule

// File: rtl/mbus_strobe_gen.sv
module mbus_strobe_gen (
  input  logic clk,
  input  logic rst,
  input  logic cyc_req,
  input  logic rd_req,
  input  logic wr_req,
  input  logic wr_rs_send,
  output logic cyc_q,
  output logic rd_q,
  output logic wr_q,
  output logic wrs_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= 1'b0;
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      wrs_q <= 1'b0;
    end else begin
      rd_q  <= rd_req;
      wr_q  <= wr_req;
      cyc_q <= cyc_req & (rd_req | wr_req);
      wrs_q <= wr_rs_send & ~wrs_q;
    end
  end
endmodule

// File: rtl/mbus_edge_pulse.sv
module mbus_edge_pulse #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  output logic [N-1:0] pulses
);
  logic [N-1:0] prev;
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        prev[i]   <= 1'b0;
        pulses[i] <= 1'b0;
      end else begin
        prev[i]   <= lines[i];
        pulses[i] <= lines[i] & ~prev[i];
      end
    end
  end
endmodule

// File: rtl/mbus_req_enc.sv
module mbus_req_enc
  import mbus_req_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [17:0]       rel_addr,
  input  logic [7:0]        reloc,
  input  logic              addr_load,
  input  logic              fast_sel,
  input  logic              cyc_req,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              wr_rs_send,
  input  logic              ack_in,
  input  logic              rdrs_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [31:0]       bus_ctl,
  output logic              ack_pulse,
  output logic              rdrs_pulse,
  output logic [DATA_W-1:0] mbuf
);
  logic [CTL_W-1:0] fields;
  logic cyc_q, rd_q, wr_q, wrs_q;
  logic [EDGE_N-1:0] pulses;

  mbus_addr_packer u_pack (
    .clk(clk), .rst(rst), .load(addr_load), .rel_addr(rel_addr),
    .reloc(reloc), .fast_sel(fast_sel), .fields(fields)
  );

  mbus_strobe_gen u_strb (
    .clk(clk), .rst(rst), .cyc_req(cyc_req), .rd_req(rd_req),
    .wr_req(wr_req), .wr_rs_send(wr_rs_send),
    .cyc_q(cyc_q), .rd_q(rd_q), .wr_q(wr_q), .wrs_q(wrs_q)
  );

  mbus_edge_pulse #(.N(EDGE_N)) u_edge (
    .clk(clk), .rst(rst), .lines({rdrs_in, ack_in}), .pulses(pulses)
  );

  assign ack_pulse  = pulses[0];
  assign rdrs_pulse = pulses[1];

  always_comb begin
    bus_ctl = fields;
    bus_ctl[B_CYC] = cyc_q;
    bus_ctl[B_RD]  = rd_q;
    bus_ctl[B_WR]  = wr_q;
    bus_ctl[B_WRS] = wrs_q;
  end

  always_ff @(posedge clk) begin
    if (rst || addr_load) mbuf <= '0;
    else if (rd_q)        mbuf <= mbuf | rdata;
  end
endmodule

// File: rtl/mbus_req_enc_chk.sv
module mbus_req_enc_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_load,
  input logic              ack_in,
  input logic              rdrs_in,
  input logic [31:0]       bus_ctl,
  input logic              ack_pulse,
  input logic              rdrs_pulse,
  input logic [DATA_W-1:0] mbuf
);
  p_cyc_gated_r8: assert property (@(posedge clk) disable iff (rst)
    bus_ctl[28] |-> (bus_ctl[29] | bus_ctl[30]));

  p_wrs_single_r9: assert property (@(posedge clk) disable iff (rst)
    bus_ctl[31] |=> !bus_ctl[31]);

  p_ack_edge_r10: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |-> ($past(ack_in) && !$past(ack_pulse)));

  p_rdrs_edge_r10: assert property (@(posedge clk) disable iff (rst)
    rdrs_pulse |-> ($past(rdrs_in) && !$past(rdrs_pulse)));

  p_pairs_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(addr_load) && !$past(rst)) |->
      ((bus_ctl[18] ^ bus_ctl[19]) && (bus_ctl[20] ^ bus_ctl[21]) &&
       (bus_ctl[22] ^ bus_ctl[23]) && (bus_ctl[24] ^ bus_ctl[25])));

  p_lsb_pair_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(bus_ctl[27:26]) <= 1);

  p_sel_pair_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(bus_ctl[2:1]) <= 1);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !addr_load |=> $stable(bus_ctl[27:0]));

  p_load_clears_r11: assert property (@(posedge clk) disable iff (rst)
    addr_load |=> (mbuf == '0));
endmodule

bind mbus_req_enc mbus_req_enc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .addr_load(addr_load), .ack_in(ack_in),
  .rdrs_in(rdrs_in), .bus_ctl(bus_ctl), .ack_pulse(ack_pulse),
  .rdrs_pulse(rdrs_pulse), .mbuf(mbuf)
);

// File: tb/mbus_req_enc_tb.sv
`timescale 1ns/1ps
module mbus_req_enc_tb;
  localparam int DW = 36;
  logic clk = 1'b0;
  logic rst;
  logic [17:0] rel_addr;
  logic [7:0]  reloc;
  logic addr_load, fast_sel, cyc_req, rd_req, wr_req, wr_rs_send;
  logic ack_in, rdrs_in;
  logic [DW-1:0] rdata;
  logic [31:0] bus_ctl;
  logic ack_pulse, rdrs_pulse;
  logic [DW-1:0] mbuf;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  mbus_req_enc #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .rel_addr(rel_addr), .reloc(reloc),
    .addr_load(addr_load), .fast_sel(fast_sel), .cyc_req(cyc_req),
    .rd_req(rd_req), .wr_req(wr_req), .wr_rs_send(wr_rs_send),
    .ack_in(ack_in), .rdrs_in(rdrs_in), .rdata(rdata), .bus_ctl(bus_ctl),
    .ack_pulse(ack_pulse), .rdrs_pulse(rdrs_pulse), .mbuf(mbuf)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] exp_fields(input logic [17:0] ra, input logic [7:0] rl,
                                             input logic fs);
    logic [27:0] w;
    logic [7:0] b;
    b = 8'((ra >> 10) + rl);
    w = '0;
    w[0] = b[4];
    w[1] = fs;
    w[2] = !fs;
    for (int i = 0; i < 10; i++) w[4+i] = ra[i];
    for (int i = 0; i < 4; i++) w[14+i] = b[i];
    for (int k = 0; k < 4; k++) begin
      w[18+2*k] = b[4+k];
      w[19+2*k] = !b[4+k];
    end
    w[26] = ra[0];
    w[27] = !ra[0];
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rls [5];
    logic [27:0] prev;
    rls[0] = 8'h00; rls[1] = 8'h01; rls[2] = 8'h55; rls[3] = 8'hFF; rls[4] = 8'h80;
    rst = 1'b1;
    rel_addr = '0; reloc = '0; addr_load = 0; fast_sel = 0;
    cyc_req = 0; rd_req = 0; wr_req = 0; wr_rs_send = 0;
    ack_in = 0; rdrs_in = 0; rdata = '0;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 bus_ctl", 64'(bus_ctl), 0);
    chk("R1 pulses", 64'({ack_pulse, rdrs_pulse}), 0);
    chk("R1 mbuf", 64'(mbuf), 0);

    // R2..R7 relocation and packing sweep
    for (int r = 0; r < 5; r++) begin
      for (int b = 0; b < 256; b++) begin
        logic [17:0] ra;
        logic fs;
        ra = {8'(b), 10'((b * 37 + r * 101) & 10'h3ff)};
        fs = ra[0] ^ ra[10] ^ 1'(r);
        @(negedge clk);
        rel_addr = ra; reloc = rls[r]; fast_sel = fs; addr_load = 1;
        tick();
        addr_load = 0;
        chk("R2 R3 R4 R5 R6 packed fields", 64'(bus_ctl[27:0]), 64'(exp_fields(ra, rls[r], fs)));
        chk("R6 spare bit3", 64'(bus_ctl[3]), 0);
        if (b % 64 == 0) begin
          prev = bus_ctl[27:0];
          rel_addr = ~ra; reloc = ~rls[r]; fast_sel = ~fs;
          tick();
          chk("R7 hold without load", 64'(bus_ctl[27:0]), 64'(prev));
        end
      end
    end

    // R8 strobe gating, all combinations
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      cyc_req = v[2]; rd_req = v[1]; wr_req = v[0];
      tick();
      chk("R8 strobes", 64'(bus_ctl[30:28]),
          64'({v[0] != 0, v[1] != 0, (v[2] != 0) && (v[1] != 0 || v[0] != 0)}));
    end
    // R8 cycle request tracks a read flag change with cyc held
    @(negedge clk); cyc_req = 1; rd_req = 0; wr_req = 0; tick();
    chk("R8 cyc without rd/wr", 64'(bus_ctl[28]), 0);
    rd_req = 1; tick();
    chk("R8 cyc after rd set", 64'(bus_ctl[28]), 1);
    rd_req = 0; tick();
    chk("R8 cyc after rd cleared", 64'(bus_ctl[28]), 0);
    cyc_req = 0;

    // R9 write restart self-clears
    @(negedge clk); wr_rs_send = 1; tick();
    chk("R9 wrs raised", 64'(bus_ctl[31]), 1);
    wr_rs_send = 0; tick();
    chk("R9 wrs cleared", 64'(bus_ctl[31]), 0);

    // R10 leading-edge pulses
    @(negedge clk); ack_in = 1; tick();
    chk("R10 ack pulse", 64'({ack_pulse, rdrs_pulse}), 64'(2'b10));
    tick();
    chk("R10 ack held no pulse", 64'(ack_pulse), 0);
    ack_in = 0; rdrs_in = 1; tick();
    chk("R10 rdrs pulse", 64'({ack_pulse, rdrs_pulse}), 64'(2'b01));
    ack_in = 1; tick();
    chk("R10 ack re-edge, rdrs held", 64'({ack_pulse, rdrs_pulse}), 64'(2'b10));
    ack_in = 0; rdrs_in = 0; tick();
    chk("R10 idle", 64'({ack_pulse, rdrs_pulse}), 0);

    // R11 read data accumulate
    rd_req = 0; rdata = '0; addr_load = 1; tick(); addr_load = 0;
    rdata = 36'h0F0F0F0F0; tick(); tick();
    chk("R11 ignored without read", 64'(mbuf), 0);
    rdata = '0; rd_req = 1; tick();
    rdata = 36'h0F0F0F0F0; tick();
    chk("R11 first word", 64'(mbuf), 64'(36'h0F0F0F0F0));
    rdata = 36'h00FF00FF3; tick();
    chk("R11 accumulate", 64'(mbuf), 64'(36'h0FFF0FFF3));
    rdata = 36'hA00000000; addr_load = 1; tick(); addr_load = 0;
    chk("R11 load clears", 64'(mbuf), 0);
    rd_req = 0; rdata = '0; tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule